// File: doc/BRIEF.md
# Glitch-free two-source clock switch

This block chooses between two unrelated clocks and sends the chosen one to four identical output copies. A change of the select input never shortens a high phase or creates a runt pulse. The block first shuts the old path while the old clock is low. It then hands the right to drive the output across to the new clock's domain. The new path opens only while the new clock is low.

Each path has a two-stage gate that is clocked on the falling edge of its own clock. It samples the select line together with the state of the other path's gate. A forced-switch control covers a source that has died, whether it stopped at a high or a low level. Here a request synchronized in the new clock's domain clears the old gate at once, so the handover never waits for an edge that will not come. Two controls act on the output at all times, whatever either clock does: an asynchronous enable that parks the output at a chosen static level, and a power-down that holds it low.

Top module: `clk_switch2`

## Requirements
- R1: With `sel` = 0 the output copies follow `clk_a`. With `sel` = 1 they follow `clk_b`. A path's gate opens only while the select points at that path.
- R2: While `rst_n` is low both gates are closed and the outputs are low. After release, with `sel` = 0, the outputs follow `clk_a` from the 2nd or 3rd rising edge of `clk_a`.
- R3: The two gates are never open at the same time.
- R4: After `sel` changes, the old gate closes on the second falling edge of the old clock, and the outputs stay low from then on. The first high output comes on the 2nd or 3rd rising edge of the new clock after that close. The new gate opens only after the old one has closed.
- R5: Every high pulse on the outputs lasts exactly one high phase of the selected clock, including across switches.
- R6: With `force_sw` high and `sel` pointing at the new source, the handover completes even when the old clock is stopped at either level. The first high output comes on the 4th or 5th rising edge of the new clock.
- R7: With `force_sw` low, a stopped old clock blocks the handover: the outputs hold the level at which the old clock stopped.
- R8: With `out_en` low and `pwr_dn` low, all outputs drive `park_hi` at once, independent of either clock.
- R9: With `pwr_dn` high, all outputs are low, whatever `out_en` and `park_hi` are.
- R10: The four output copies are always identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Primary clock source |
| clk_b | input | 1 | Secondary clock source |
| rst_n | input | 1 | Asynchronous active-low reset; closes both gates |
| sel | input | 1 | Source choice: 0 selects clk_a, 1 selects clk_b |
| force_sw | input | 1 | Forced handover when the old source is dead; must be low at reset |
| out_en | input | 1 | Asynchronous output enable, 1 = clock passes |
| park_hi | input | 1 | Static output level while disabled |
| pwr_dn | input | 1 | Power-down: holds all outputs low |
| clk_out | output | NOUT (4) | Identical copies of the selected clock |

## Verification
The handover is driven in both directions at random moments and in both phases of the old clock. This tells a switch that waits the right number of edges on each side apart from one that closes too late or opens too early. A pulse-width monitor meanwhile catches any clipped high phase. Dead-source runs stop the old clock low and then high, first with the forced control low and then high. These runs separate a blocked handover from a forced one and show whether the forced path really ignores the old clock. Random mixes of enable, park level and power-down, sampled in both clock phases, check that the two static overrides take precedence in the right order.

// File: rtl/clk_switch2.sv
`timescale 1ns/100ps
module clk_switch2 #(
  parameter int NOUT = 4
) (
  input  logic            clk_a,
  input  logic            clk_b,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            force_sw,
  input  logic            out_en,
  input  logic            park_hi,
  input  logic            pwr_dn,
  output logic [NOUT-1:0] clk_out
);

  logic a_s1, a_on, b_s1, b_on;
  logic fa_s1, fa_s2, fb_s1, fb_s2;

  wire a_clr_n  = rst_n & ~fb_s2;
  wire b_clr_n  = rst_n & ~fa_s2;
  wire fa_clr_n = rst_n & ~sel;
  wire fb_clr_n = rst_n & sel;

  always_ff @(negedge clk_a or negedge a_clr_n)
    if (!a_clr_n) begin
      a_s1 <= 1'b0;
      a_on <= 1'b0;
    end else begin
      a_s1 <= ~sel & ~b_on;
      a_on <= a_s1;
    end

  always_ff @(negedge clk_b or negedge b_clr_n)
    if (!b_clr_n) begin
      b_s1 <= 1'b0;
      b_on <= 1'b0;
    end else begin
      b_s1 <= sel & ~a_on;
      b_on <= b_s1;
    end

  // forced request, synchronized in the clock domain being switched to
  always_ff @(negedge clk_a or negedge fa_clr_n)
    if (!fa_clr_n) begin
      fa_s1 <= 1'b0;
      fa_s2 <= 1'b0;
    end else begin
      fa_s1 <= force_sw;
      fa_s2 <= fa_s1;
    end

  always_ff @(negedge clk_b or negedge fb_clr_n)
    if (!fb_clr_n) begin
      fb_s1 <= 1'b0;
      fb_s2 <= 1'b0;
    end else begin
      fb_s1 <= force_sw;
      fb_s2 <= fb_s1;
    end

  wire picked = (clk_a & a_on) | (clk_b & b_on);
  wire level  = pwr_dn ? 1'b0 : (out_en ? picked : park_hi);

  assign clk_out = {NOUT{level}};

  p_gate_mutex_r3: assert property (@(negedge clk_a) disable iff (!rst_n)
    !(a_on && b_on));
  p_a_after_b_r4: assert property (@(negedge clk_a) disable iff (!rst_n)
    $rose(a_on) |-> !b_on);
  p_b_after_a_r4: assert property (@(negedge clk_b) disable iff (!rst_n)
    $rose(b_on) |-> !a_on);
  p_a_needs_sel_r1: assert property (@(negedge clk_a) disable iff (!rst_n)
    $rose(a_on) |-> !$past(sel));
  p_b_needs_sel_r1: assert property (@(negedge clk_b) disable iff (!rst_n)
    $rose(b_on) |-> $past(sel));

endmodule

// File: tb/tb_clk_switch2.sv
`timescale 1ns/100ps
module tb_clk_switch2;
  logic clk_a = 0, clk_b = 0, rst_n = 0, sel = 0, force_sw = 0;
  logic out_en = 1, park_hi = 0, pwr_dn = 0;
  wire [3:0] clk_out;
  bit a_run = 1, b_run = 1, mon_on = 0, done = 0;
  int checks = 0, fails = 0;
  real t_rise = -1.0;

  clk_switch2 dut (.clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel),
    .force_sw(force_sw), .out_en(out_en), .park_hi(park_hi), .pwr_dn(pwr_dn),
    .clk_out(clk_out));

  // clk_a: 50 MHz; clk_b: unrelated 34 ns period
  always begin #10; if (a_run) clk_a = ~clk_a; end
  always begin #17; if (b_run) clk_b = ~clk_b; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_out(input bit pd, input bit en, input bit lvl, input bit src);
    if (pd) return 4'h0;
    if (!en) return {4{lvl}};
    return {4{src}};
  endfunction

  // R5: every high pulse is one full high phase (10 ns or 17 ns)
  always @(posedge clk_out[0]) t_rise = $realtime;
  always @(negedge clk_out[0])
    if (mon_on && t_rise >= 0.0) begin
      real w;
      w = $realtime - t_rise;
      chk(w == 10.0 || w == 17.0, "R5 pulse width", int'(w), sel ? 17 : 10);
    end

  // R1/R10 (and R3, since a mixed output breaks the strict copy)
  task automatic follow(input bit use_b, input string req, input int n);
    repeat (n) begin
      if (use_b) @(posedge clk_b); else @(posedge clk_a);
      #2.5 chk(clk_out == 4'hF, {req, " R10 high"}, clk_out, 15);
      if (use_b) @(negedge clk_b); else @(negedge clk_a);
      #2.5 chk(clk_out == 4'h0, {req, " R10 low"}, clk_out, 0);
    end
  endtask

  task automatic handover(input bit to_b);
    int cnt;
    if (to_b) @(negedge clk_a); else @(negedge clk_b);
    #1 sel = to_b;
    repeat (2) begin
      if (to_b) @(negedge clk_a); else @(negedge clk_b);
    end
    #1;
    fork
      begin
        if (to_b) @(posedge clk_a); else @(posedge clk_b);
        #1 chk(clk_out == 4'h0, "R4 old gate closed", clk_out, 0);
      end
    join_none
    cnt = 0;
    while (cnt < 8) begin
      if (to_b) @(posedge clk_b); else @(posedge clk_a);
      cnt++;
      #1;
      if (clk_out[0]) break;
    end
    chk(cnt >= 2 && cnt <= 3, "R4 new clock edges", cnt, 3);
    follow(to_b, "R1 new source", 3);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    repeat (4) #7.3 chk(clk_out == 4'h0, "R2 reset low", clk_out, 0);
    @(negedge clk_a); #3 rst_n = 1;
    cnt = 0;
    while (cnt < 8) begin
      @(posedge clk_a); cnt++; #1;
      if (clk_out[0]) break;
    end
    chk(cnt >= 2 && cnt <= 3, "R2 start-up edges", cnt, 3);
    follow(0, "R2 follows clk_a", 3);

    // random switching with pulse monitor
    mon_on = 1;
    for (int i = 0; i < 12; i++) begin
      #($urandom_range(5, 200));
      handover(~sel);
    end
    mon_on = 0;

    // random static overrides, sampled off the clock edges
    for (int i = 0; i < 40; i++) begin
      out_en  = $urandom_range(0, 1);
      park_hi = $urandom_range(0, 1);
      pwr_dn  = ($urandom_range(0, 3) == 0);
      #($urandom_range(3, 60) + 0.5);
      chk(clk_out == exp_out(pwr_dn, out_en, park_hi, sel ? clk_b : clk_a),
          pwr_dn ? "R9 power-down" : (!out_en ? "R8 parked level" : "R1 enabled"),
          clk_out, exp_out(pwr_dn, out_en, park_hi, sel ? clk_b : clk_a));
      chk(clk_out == 4'h0 || clk_out == 4'hF, "R10 copies equal", clk_out, 0);
    end
    // directed: power-down overrides a parked high and a high clock
    out_en = 0; park_hi = 1; pwr_dn = 1; #3.5
    chk(clk_out == 4'h0, "R9 over park", clk_out, 0);
    out_en = 1;
    if (sel) @(posedge clk_b); else @(posedge clk_a);
    #2.5 chk(clk_out == 4'h0, "R9 over clock", clk_out, 0);
    pwr_dn = 0; park_hi = 0; out_en = 0; #3.5
    chk(clk_out == 4'h0, "R8 park low", clk_out, 0);
    out_en = 1;
    if (sel) handover(0);

    // dead source stopped low
    @(negedge clk_a); #1 a_run = 0; sel = 1;
    repeat (12) begin
      @(posedge clk_b); #2.5 chk(clk_out == 4'h0, "R7 blocked low", clk_out, 0);
    end
    force_sw = 1;
    cnt = 0;
    while (cnt < 10) begin
      @(posedge clk_b); cnt++; #1;
      if (clk_out[0]) break;
    end
    chk(cnt >= 4 && cnt <= 5, "R6 forced edges", cnt, 5);
    follow(1, "R6 forced follow", 3);
    force_sw = 0; a_run = 1;
    repeat (3) @(posedge clk_b);
    handover(0);

    // dead source stopped high
    @(posedge clk_a); #1 a_run = 0; sel = 1;
    repeat (6) begin
      @(posedge clk_b); #2.5 chk(clk_out == 4'hF, "R7 blocked high", clk_out, 15);
    end
    force_sw = 1;
    repeat (6) @(posedge clk_b);
    follow(1, "R6 forced from high", 3);
    force_sw = 0; a_run = 1;
    repeat (3) @(posedge clk_b);
    handover(0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule